// File: doc/BRIEF.md
# Dual-Range RSSI Result Selector

This block sits behind a receive-power converter that produces two results for every sample: one from a sensitive fine range and one from a wide coarse range. It turns each pair into a single reported 16-bit left-justified value. In automatic operation it tracks which range is in use and switches between them with hysteresis. The upward switch happens when the fine result saturates. The downward switch happens only once the coarse result falls clearly below a programmable crossover value. A 2-bit mode field can instead force either range.

When the coarse range is reported and clamping is enabled, coarse values below the crossover register are raised to the crossover value. This keeps nonlinear low-end readings from going under the crossover. Range selection and clamping both happen first. A logical right shift of 0 to 7 bits is applied last, so a reduced full scale still gives correctly weighted LSBs. Each sample produces a one-cycle update strobe, and a flag with the result shows which range produced it.

Top module: `rssi_range_sel`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `result` is 0, `coarse_used` is 0 and `result_valid` is 0. The remembered range after reset is fine.
- R2: `result_valid` is high for exactly the cycle after each cycle in which `sample_valid` is high, and low at all other times. Without a sample, `result` and `coarse_used` hold their values.
- R3: `mode` is decoded as follows: 2'b01 forces the fine range, 2'b10 forces the coarse range, and both 2'b11 and 2'b00 select automatic ranging.
- R4: In automatic mode with fine remembered, a sample whose `fine_raw` equals 16'hFFFF is reported from the coarse range. Coarse becomes the remembered range. Any other fine value is reported from fine.
- R5: In automatic mode with coarse remembered, a sample is reported from fine, and fine becomes remembered, only when `coarse_raw` is below `xover` minus the hysteresis margin (parameter `HYST`, default 256). The subtraction saturates at 0. Otherwise the sample stays coarse.
- R6: When the coarse range is reported, `clamp_en` is 1 and `coarse_raw` < `xover`, the value before shifting is `xover`. Fine results are never clamped.
- R7: `result` equals the selected (and possibly clamped) value logically shifted right by `rshift` (0 to 7), with zeros filled at the top.
- R8: `coarse_used` is 1 when the value in `result` came from the coarse range and 0 when it came from fine.
- R9: A forced mode also sets the remembered range. Automatic ranging resumes from the range of the last reported sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | A new fine/coarse result pair is present |
| fine_raw | input | 16 | Fine-range conversion result, left-justified |
| coarse_raw | input | 16 | Coarse-range conversion result, left-justified |
| xover | input | 16 | Crossover value used for hysteresis and clamping |
| clamp_en | input | 1 | Enables the crossover clamp on coarse results |
| mode | input | 2 | Range mode: 01 fine, 10 coarse, 00/11 automatic |
| rshift | input | 3 | Right-shift count applied to the final value |
| result | output | 16 | Reported receive-power value |
| coarse_used | output | 1 | 1 when `result` came from the coarse range |
| result_valid | output | 1 | One-cycle strobe marking an updated `result` |

## Verification
The only hidden state is the remembered range bit. If it is wrong, the next automatic sample is reported from the other range. That shows on `coarse_used`, and usually on `result`, in the cycle after that sample. The bench therefore runs samples in the hysteresis band right after each range change and after each forced-mode sample, so a stale or wrongly updated range bit is caught within one sample. Errors in clamping and shifting appear directly in the same strobe cycle. They are exercised at the crossover boundary, at a saturating crossover and at the extreme shift counts.

// File: rtl/rssi_sel_pkg.sv
package rssi_sel_pkg;

    localparam int RES_W   = 16;
    localparam int SHIFT_W = 3;
    localparam logic [RES_W-1:0] RES_FULL = {RES_W{1'b1}};

    typedef logic [RES_W-1:0]   res_t;
    typedef logic [SHIFT_W-1:0] shift_t;

    typedef enum logic [1:0] {
        MODE_AUTO_ALT = 2'b00,
        MODE_FINE     = 2'b01,
        MODE_COARSE   = 2'b10,
        MODE_AUTO     = 2'b11
    } range_mode_e;

    typedef enum logic {
        RNG_FINE   = 1'b0,
        RNG_COARSE = 1'b1
    } range_e;

    typedef struct packed {
        range_e rng;
        res_t   value;
    } report_t;

    function automatic res_t sat_sub(input res_t a, input res_t b);
        return (a > b) ? res_t'(a - b) : '0;
    endfunction

    function automatic logic is_auto(input range_mode_e m);
        return (m == MODE_AUTO) || (m == MODE_AUTO_ALT);
    endfunction

endpackage

// File: rtl/rssi_range_ctrl.sv
module rssi_range_ctrl
    import rssi_sel_pkg::*;
#(
    parameter res_t HYST = res_t'(256)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sample_valid,
    input  range_mode_e mode,
    input  res_t        fine_raw,
    input  res_t        coarse_raw,
    input  res_t        xover,
    output range_e      range_sel
);

    range_e rng_q;
    res_t   drop_thr;

    always_comb begin
        drop_thr  = sat_sub(xover, HYST);
        range_sel = rng_q;
        unique case (mode)
            MODE_FINE:   range_sel = RNG_FINE;
            MODE_COARSE: range_sel = RNG_COARSE;
            default: begin
                if (rng_q == RNG_FINE)
                    range_sel = (fine_raw == RES_FULL) ? RNG_COARSE : RNG_FINE;
                else
                    range_sel = (coarse_raw < drop_thr) ? RNG_FINE : RNG_COARSE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rng_q <= RNG_FINE;
        else if (sample_valid)
            rng_q <= range_sel;
    end

    // R4: a saturated fine sample in automatic mode must leave fine range
    a_r4_up_on_full: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && is_auto(mode) && rng_q == RNG_FINE && fine_raw == RES_FULL)
        |=> (rng_q == RNG_COARSE));

    // R5: inside the hysteresis band coarse range is kept
    a_r5_band_holds: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && is_auto(mode) && rng_q == RNG_COARSE && coarse_raw >= drop_thr)
        |=> (rng_q == RNG_COARSE));

endmodule

// File: rtl/rssi_value_path.sv
module rssi_value_path
    import rssi_sel_pkg::*;
(
    input  range_e  range_sel,
    input  res_t    fine_raw,
    input  res_t    coarse_raw,
    input  res_t    xover,
    input  logic    clamp_en,
    input  shift_t  rshift,
    output report_t report
);

    res_t picked;
    res_t stage [0:SHIFT_W];

    always_comb begin
        if (range_sel == RNG_COARSE)
            picked = (clamp_en && coarse_raw < xover) ? xover : coarse_raw;
        else
            picked = fine_raw;
    end

    assign stage[0] = picked;

    generate
        for (genvar g = 0; g < SHIFT_W; g++) begin : g_shift
            assign stage[g+1] = rshift[g] ? (stage[g] >> (1 << g)) : stage[g];
        end
    endgenerate

    assign report.rng   = range_sel;
    assign report.value = stage[SHIFT_W];

    // R6: a clamped coarse value never sits below the crossover
    always_comb begin
        a_r6_clamp_floor: assert (!(range_sel == RNG_COARSE && clamp_en) || picked >= xover);
    end

endmodule

// File: rtl/rssi_range_sel.sv
module rssi_range_sel
    import rssi_sel_pkg::*;
#(
    parameter res_t HYST = res_t'(256)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sample_valid,
    input  logic [15:0] fine_raw,
    input  logic [15:0] coarse_raw,
    input  logic [15:0] xover,
    input  logic        clamp_en,
    input  logic [1:0]  mode,
    input  logic [2:0]  rshift,
    output logic [15:0] result,
    output logic        coarse_used,
    output logic        result_valid
);

    range_e      range_sel;
    report_t     report;
    range_mode_e mode_e;

    assign mode_e = range_mode_e'(mode);

    rssi_range_ctrl #(.HYST(HYST)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .mode         (mode_e),
        .fine_raw     (fine_raw),
        .coarse_raw   (coarse_raw),
        .xover        (xover),
        .range_sel    (range_sel)
    );

    rssi_value_path u_path (
        .range_sel  (range_sel),
        .fine_raw   (fine_raw),
        .coarse_raw (coarse_raw),
        .xover      (xover),
        .clamp_en   (clamp_en),
        .rshift     (rshift),
        .report     (report)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result       <= '0;
            coarse_used  <= 1'b0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= sample_valid;
            if (sample_valid) begin
                result      <= report.value;
                coarse_used <= (report.rng == RNG_COARSE);
            end
        end
    end

    // R2: strobe only after a sample
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(sample_valid));

    // R2: outputs hold without a sample
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> ($stable(result) && $stable(coarse_used)));

    // R3: forced fine reports fine
    a_r3_forced_fine: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && mode == 2'b01) |=> !coarse_used);

    // R3: forced coarse reports coarse
    a_r3_forced_coarse: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && mode == 2'b10) |=> coarse_used);

    // R7: the shifted result fits under the shifted full scale
    a_r7_shift_bound: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> (result <= (RES_FULL >> $past(rshift))));

endmodule

// File: tb/rssi_range_sel_tb_top.sv
module rssi_range_sel_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HYST_TB    = 256;

    logic        clk = 1'b0;
    logic        rst;
    logic        sample_valid;
    logic [15:0] fine_raw, coarse_raw, xover;
    logic        clamp_en;
    logic [1:0]  mode;
    logic [2:0]  rshift;
    logic [15:0] result;
    logic        coarse_used;
    logic        result_valid;

    int tests = 0;
    int fails = 0;

    // reference state
    int          m_coarse;
    int          m_res;
    int          m_cu;
    int          m_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    rssi_range_sel #(.HYST(16'(HYST_TB))) dut_i (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .fine_raw(fine_raw), .coarse_raw(coarse_raw), .xover(xover),
        .clamp_en(clamp_en), .mode(mode), .rshift(rshift),
        .result(result), .coarse_used(coarse_used), .result_valid(result_valid)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("[TB] FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic sv, input int f, input int c, input int x,
                         input logic cl, input int md, input int sh);
        int thr;
        int sel;
        int val;
        if (!sv) begin
            m_v = 0;
            return;
        end
        thr = (x > HYST_TB) ? x - HYST_TB : 0;
        if (md == 1)      sel = 0;
        else if (md == 2) sel = 1;
        else if (m_coarse == 0) sel = (f == 16'hFFFF) ? 1 : 0;
        else              sel = (c < thr) ? 0 : 1;
        m_coarse = sel;
        if (sel == 1) val = (cl && c < x) ? x : c;
        else          val = f;
        m_res = val >> sh;
        m_cu  = sel;
        m_v   = 1;
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic sv, input int f, input int c, input int x,
                        input logic cl, input int md, input int sh, input string tag);
        sample_valid = sv;
        fine_raw     = 16'(f);
        coarse_raw   = 16'(c);
        xover        = 16'(x);
        clamp_en     = cl;
        mode         = 2'(md);
        rshift       = 3'(sh);
        @(posedge clk);
        model(sv, f, c, x, cl, md, sh);
        @(negedge clk);
        check(tag, "result_valid", int'(result_valid), m_v);
        check(tag, "result", int'(result), m_res);
        check(tag, "coarse_used", int'(coarse_used), m_cu);
    endtask

    task automatic smp(input int f, input int c, input int x, input logic cl,
                       input int md, input int sh, input string tag);
        step(1'b1, f, c, x, cl, md, sh, tag);
        step(1'b0, 16'h5A5A, 16'hA5A5, x, cl, md, sh, "R2");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("[TB] FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        sample_valid = 1'b0;
        fine_raw = '0; coarse_raw = '0; xover = '0;
        clamp_en = 1'b0; mode = 2'b11; rshift = '0;
        m_coarse = 0; m_res = 0; m_cu = 0; m_v = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "result", int'(result), 0);
        check("R1", "coarse_used", int'(coarse_used), 0);
        check("R1", "result_valid", int'(result_valid), 0);
        rst = 1'b0;
        step(1'b0, 0, 0, 16'h0400, 1'b0, 3, 0, "R1");

        // R3 automatic codes 11 and 00, fine kept
        smp(16'h1234, 16'h0800, 16'h0400, 1'b0, 3, 0, "R3");
        smp(16'h2345, 16'h0800, 16'h0400, 1'b0, 0, 0, "R3");
        // R4 saturation moves to coarse, R8 flag
        smp(16'hFFFF, 16'h0900, 16'h0400, 1'b0, 3, 0, "R4");
        // R5 band (threshold 0x0300) stays coarse
        smp(16'h0100, 16'h0350, 16'h0400, 1'b0, 3, 0, "R5");
        smp(16'h0100, 16'h0300, 16'h0400, 1'b0, 0, 0, "R5");
        // R6 clamp raises coarse to crossover
        smp(16'h0100, 16'h0350, 16'h0400, 1'b1, 3, 0, "R6");
        // R5 drop below threshold goes fine
        smp(16'h7000, 16'h02FF, 16'h0400, 1'b1, 3, 0, "R5");
        // R6 fine not clamped
        smp(16'h0010, 16'h0010, 16'h0400, 1'b1, 3, 0, "R6");
        // R7 shifts
        smp(16'hABCD, 16'h0000, 16'h0400, 1'b0, 3, 3, "R7");
        smp(16'hFFFE, 16'h0000, 16'h0400, 1'b0, 3, 7, "R7");
        // R3 forced coarse, R9 auto resumes coarse in band
        smp(16'h0020, 16'h1111, 16'h0400, 1'b0, 2, 1, "R3");
        smp(16'h0020, 16'h0380, 16'h0400, 1'b0, 3, 0, "R9");
        // R5 saturating threshold: xover below HYST, coarse 0 stays coarse
        smp(16'h0020, 16'h0000, 16'h0080, 1'b0, 3, 0, "R5");
        smp(16'h0020, 16'h0000, 16'h0080, 1'b1, 3, 2, "R6");
        // R3 forced fine with saturated fine, R9 auto resumes fine
        smp(16'hFFFF, 16'h2222, 16'h0400, 1'b0, 1, 0, "R3");
        smp(16'h4444, 16'h0000, 16'h0400, 1'b0, 3, 0, "R9");
        smp(16'hFFFF, 16'h3333, 16'h0400, 1'b0, 3, 4, "R8");
        // back-to-back samples
        step(1'b1, 16'h1000, 16'h0100, 16'h0400, 1'b0, 3, 0, "R2");
        step(1'b1, 16'h1000, 16'h0100, 16'h0400, 1'b0, 3, 0, "R2");
        step(1'b0, 0, 0, 16'h0400, 1'b0, 3, 0, "R2");
        // reset again mid-run
        rst = 1'b1;
        @(posedge clk);
        m_coarse = 0; m_res = 0; m_cu = 0; m_v = 0;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "result", int'(result), 0);
        check("R1", "coarse_used", int'(coarse_used), 0);
        smp(16'h0500, 16'h0100, 16'h0400, 1'b0, 3, 0, "R1");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule